// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes charge of the command and address pins of a four-bank synchronous DRAM from reset until the memory can accept normal traffic. After reset it holds NOP on the pins for a stabilization period. The length of that period comes from a clock-frequency parameter and a microsecond parameter. It then precharges every bank and issues a fixed number of AUTO REFRESH commands. It also loads the mode register with a static word supplied on an input. Between commands it inserts NOP gaps whose lengths are parameters. When the last gap has run out it raises a sticky done flag and parks the pins on NOP.

A static input chooses the ordering. Either all refreshes run before the mode load, or the mode load runs first and the refreshes follow. The choice is captured during the stabilization period, so a change after that period has no effect on the current run. Every pin is driven straight from a flop that updates on the rising clock edge.

The controller is a single state machine with eight named states. `ST_POWERUP` counts the stabilization delay and moves to `ST_PRECHARGE`. The precharge step moves to `ST_WAIT_RP`. From there the machine goes to `ST_REFRESH` when refreshes come first, or to `ST_LOADMODE` when they come second. `ST_REFRESH` moves to `ST_WAIT_RFC`. That wait returns to `ST_REFRESH` until the refresh count is reached. After that it goes to `ST_LOADMODE` in refresh-first order, or to `ST_DONE` in mode-first order. `ST_LOADMODE` moves to `ST_WAIT_MRD`. That wait goes to `ST_DONE` in refresh-first order, or to `ST_REFRESH` in mode-first order. `ST_DONE` is terminal until reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, chip select is high (command inhibit), RAS/CAS/WE are high, the address and bank outputs are zero and done is low.
- R2: From the first clock edge after reset release, NOP is driven. NOP means {cs_n,ras_n,cas_n,we_n} = 0111. No other command appears until edge number CLK_MHZ*PWRUP_US after release, at which edge the first command appears.
- R3: The first command is PRECHARGE, encoded 0010, with address bit 10 high to select all banks.
- R4: Exactly T_RP_CYC NOP cycles follow the PRECHARGE, exactly T_RFC_CYC follow each AUTO REFRESH, and exactly T_MRD_CYC follow LOAD MODE. The next step's command comes in the cycle after the gap.
- R5: Exactly NUM_REFRESH (default 2) AUTO REFRESH commands, encoded 0001, are issued per initialization.
- R6: Exactly one LOAD MODE command, encoded 0000, is issued. It carries the mode word on the 12-bit address bus and zero on the bank bits.
- R7: With refresh_first = 1 all refreshes come before LOAD MODE, and with refresh_first = 0 all come after it. The value held during the stabilization period decides the order, and later changes have no effect on the run.
- R8: Done rises in the cycle after the final gap's last NOP. It then stays high with NOP on the pins until reset.
- R9: Asserting reset at any point abandons the sequence, and a later release replays the whole sequence from the stabilization delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_word | input | 12 | Static value loaded into the mode register |
| refresh_first | input | 1 | 1: refreshes before mode load; 0: after |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address bus |
| init_done | output | 1 | Initialization complete, sticky |

## Verification
A wrong state or a mis-loaded gap counter shows at the pins as a command that lands one or more cycles off its expected edge. The bench measures every command's edge index relative to reset release, so such an error is reported at the first misplaced command. A wrong refresh count or order shows as a missing, extra or swapped command in the recorded list. A done flag raised early or late differs from the computed edge, and a done or command that is not sticky shows within the cycles observed after completion.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT   = 4'b1111,
        CMD_NOP       = 4'b0111,
        CMD_PRECHARGE = 4'b0010,
        CMD_REFRESH   = 4'b0001,
        CMD_LOADMODE  = 4'b0000
    } sdcmd_t;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RFC,
        ST_LOADMODE,
        ST_WAIT_MRD,
        ST_DONE
    } seq_state_t;

    localparam int ALLBANK_BIT = 10;

endpackage

// File: rtl/sdinit_gap_timer.sv
module sdinit_gap_timer #(
    parameter int TW       = 14,
    parameter int INIT_VAL = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= TW'(INIT_VAL);
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

    // R4: a count that has reached zero holds there until reloaded
    assert_timer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sdinit_pin_reg.sv
module sdinit_pin_reg
    import sdram_init_pkg::*;
#(
    parameter int AW = 12,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sdcmd_t        cmd_d,
    input  logic [AW-1:0] addr_d,
    input  logic [BW-1:0] ba_d,
    input  logic          done_d,
    output logic          cs_n,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic [AW-1:0] addr,
    output logic [BW-1:0] ba,
    output logic          init_done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= CMD_INHIBIT;
            addr      <= '0;
            ba        <= '0;
            init_done <= 1'b0;
        end else begin
            {cs_n, ras_n, cas_n, we_n} <= cmd_d;
            addr      <= addr_d;
            ba        <= ba_d;
            init_done <= done_d;
        end
    end

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

    assert_precharge_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == CMD_PRECHARGE) |-> addr[ALLBANK_BIT]);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ     = 125,
    parameter int PWRUP_US    = 100,
    parameter int T_RP_CYC    = 3,
    parameter int T_RFC_CYC   = 8,
    parameter int T_MRD_CYC   = 2,
    parameter int NUM_REFRESH = 2,
    parameter int AW          = 12,
    parameter int BW          = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] mode_word,
    input  logic          refresh_first,
    output logic          cs_n,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic [BW-1:0] ba,
    output logic [AW-1:0] addr,
    output logic          init_done
);
    localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
    localparam int TW        = $clog2(PWRUP_CYC + 1);
    localparam int RW        = $clog2(NUM_REFRESH + 1);
    localparam logic [TW-1:0] RP_LOAD  = TW'(T_RP_CYC - 1);
    localparam logic [TW-1:0] RFC_LOAD = TW'(T_RFC_CYC - 1);
    localparam logic [TW-1:0] MRD_LOAD = TW'(T_MRD_CYC - 1);
    localparam logic [RW-1:0] REF_LAST = RW'(NUM_REFRESH);

    seq_state_t     state_q, state_d;
    logic [RW-1:0]  ref_cnt_q;
    logic           order_q;
    logic           gap_over;
    logic           tmr_load;
    logic [TW-1:0]  tmr_val;
    sdcmd_t         cmd_d;
    logic [AW-1:0]  addr_d;
    logic [BW-1:0]  ba_d;
    logic           done_d;

    sdinit_gap_timer #(
        .TW       (TW),
        .INIT_VAL (PWRUP_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (gap_over)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWERUP;
        end else begin
            state_q <= state_d;
        end
    end

    // refresh counter and captured order
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt_q <= '0;
            order_q   <= 1'b1;
        end else begin
            if (state_q == ST_REFRESH) begin
                ref_cnt_q <= ref_cnt_q + 1'b1;
            end
            if (state_q == ST_POWERUP) begin
                order_q <= refresh_first;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWERUP:   if (gap_over) state_d = ST_PRECHARGE;
            ST_PRECHARGE: state_d = ST_WAIT_RP;
            ST_WAIT_RP:   if (gap_over) state_d = order_q ? ST_REFRESH : ST_LOADMODE;
            ST_REFRESH:   state_d = ST_WAIT_RFC;
            ST_WAIT_RFC: begin
                if (gap_over) begin
                    if (ref_cnt_q < REF_LAST) state_d = ST_REFRESH;
                    else                      state_d = order_q ? ST_LOADMODE : ST_DONE;
                end
            end
            ST_LOADMODE:  state_d = ST_WAIT_MRD;
            ST_WAIT_MRD:  if (gap_over) state_d = order_q ? ST_DONE : ST_REFRESH;
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_POWERUP;
        endcase
    end

    // timer reload on each command step
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PRECHARGE: begin tmr_load = 1'b1; tmr_val = RP_LOAD;  end
            ST_REFRESH:   begin tmr_load = 1'b1; tmr_val = RFC_LOAD; end
            ST_LOADMODE:  begin tmr_load = 1'b1; tmr_val = MRD_LOAD; end
            default:      begin tmr_load = 1'b0; tmr_val = '0;       end
        endcase
    end

    // outputs decoded from the next state, registered in the pin stage
    always_comb begin
        cmd_d  = CMD_NOP;
        addr_d = '0;
        ba_d   = '0;
        done_d = 1'b0;
        unique case (state_d)
            ST_PRECHARGE: begin
                cmd_d = CMD_PRECHARGE;
                addr_d[ALLBANK_BIT] = 1'b1;
            end
            ST_REFRESH:  cmd_d = CMD_REFRESH;
            ST_LOADMODE: begin
                cmd_d  = CMD_LOADMODE;
                addr_d = mode_word;
            end
            ST_DONE:     done_d = 1'b1;
            default:     cmd_d = CMD_NOP;
        endcase
    end

    sdinit_pin_reg #(
        .AW (AW),
        .BW (BW)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_d     (cmd_d),
        .addr_d    (addr_d),
        .ba_d      (ba_d),
        .done_d    (done_d),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ba        (ba),
        .init_done (init_done)
    );

    assert_refresh_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt_q <= REF_LAST);

    assert_order_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_POWERUP) |=> $stable(order_q));

    assert_gap_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RP || state_q == ST_WAIT_RFC || state_q == ST_WAIT_MRD)
        |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

    assert_mode_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == CMD_LOADMODE) |-> (ba == '0 && addr == $past(mode_word)));

    assert_powerup_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POWERUP) |-> ({cs_n, ras_n, cas_n, we_n} != CMD_PRECHARGE &&
                                     {cs_n, ras_n, cas_n, we_n} != CMD_REFRESH &&
                                     {cs_n, ras_n, cas_n, we_n} != CMD_LOADMODE));

endmodule

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps
module test_sdram_init_seq;

    localparam int P     = 125 * 100;
    localparam int T_RP  = 3;
    localparam int T_RFC = 8;
    localparam int T_MRD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mode_word = 12'h000;
    logic        refresh_first = 1'b1;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic        init_done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sdram_init_seq i_sdram_init_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_word     (mode_word),
        .refresh_first (refresh_first),
        .cs_n          (cs_n),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .we_n          (we_n),
        .ba            (ba),
        .addr          (addr),
        .init_done     (init_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 inhibit pins", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
        chk("R1 addr/ba zero", {ba, addr}, 14'h0);
        chk("R1 done low", init_done, 1'b0);
        rst_n = 1'b1;
    endtask

    // One full initialization; flip toggles refresh_first after the first command
    task automatic run_seq(input bit order, input logic [11:0] mword, input bit flip);
        logic [3:0]  got_cmd [8];
        int          got_t   [8];
        logic [11:0] got_a   [8];
        logic [1:0]  got_b   [8];
        logic [3:0]  exp_cmd [5];
        int          exp_t   [5];
        int n = 0;
        int illegal = 0;
        int done_t = -1;
        int t;
        refresh_first = order;
        mode_word = mword;
        do_reset();
        for (int cyc = 1; cyc < P + 200; cyc++) begin
            @(negedge clk);
            if (flip && cyc == P + 1) refresh_first = ~order;
            if (init_done) begin
                done_t = cyc;
                break;
            end
            if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                if (n < 8) begin
                    got_cmd[n] = {cs_n, ras_n, cas_n, we_n};
                    got_t[n] = cyc;
                    got_a[n] = addr;
                    got_b[n] = ba;
                end
                n++;
                if (!({cs_n, ras_n, cas_n, we_n} inside {4'b0010, 4'b0001, 4'b0000})) illegal++;
            end
        end
        t = P;
        exp_cmd[0] = 4'b0010; exp_t[0] = t; t += T_RP + 1;
        if (order) begin
            exp_cmd[1] = 4'b0001; exp_t[1] = t; t += T_RFC + 1;
            exp_cmd[2] = 4'b0001; exp_t[2] = t; t += T_RFC + 1;
            exp_cmd[3] = 4'b0000; exp_t[3] = t; t += T_MRD + 1;
        end else begin
            exp_cmd[1] = 4'b0000; exp_t[1] = t; t += T_MRD + 1;
            exp_cmd[2] = 4'b0001; exp_t[2] = t; t += T_RFC + 1;
            exp_cmd[3] = 4'b0001; exp_t[3] = t; t += T_RFC + 1;
        end
        chk("R2 only legal commands", illegal, 0);
        chk("R5 R6 command count", n, 4);
        if (n == 4) begin
            chk("R2 first command edge", got_t[0], exp_t[0]);
            chk("R3 precharge code", got_cmd[0], 4'b0010);
            chk("R3 precharge all-bank addr10", got_a[0][10], 1'b1);
            for (int k = 1; k < 4; k++) begin
                chk(flip ? "R7 order ignores late change" : "R7 command order", got_cmd[k], exp_cmd[k]);
                chk("R4 command spacing", got_t[k], exp_t[k]);
                if (got_cmd[k] == 4'b0000) begin
                    chk("R6 mode word on addr", got_a[k], mword);
                    chk("R6 bank bits zero", got_b[k], 2'b00);
                end
            end
        end
        chk("R8 done edge", done_t, t);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (!init_done || {cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                chk("R8 done sticky with NOP", {init_done, cs_n, ras_n, cas_n, we_n}, 5'b10111);
                break;
            end
        end
        total++;
    endtask

    task automatic test_order_refresh_first();
        run_seq(1'b1, 12'h032, 1'b0);
    endtask

    task automatic test_order_mode_first();
        run_seq(1'b0, 12'h5A7, 1'b0);
    endtask

    task automatic test_late_order_change();
        run_seq(1'b1, 12'h221, 1'b1);
    endtask

    task automatic test_reset_midway();
        int seen = 0;
        refresh_first = 1'b1;
        do_reset();
        for (int cyc = 1; cyc <= P + T_RP + 3; cyc++) begin
            @(negedge clk);
            if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) seen++;
        end
        chk("R9 reached refresh before abort", seen, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset abandons sequence", {cs_n, init_done}, 2'b10);
        run_seq(1'b1, 12'h0F3, 1'b0);
    endtask

    initial begin
        test_order_refresh_first();
        test_order_mode_first();
        test_late_order_change();
        test_reset_midway();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule